// File: doc/BRIEF.md
# Serial Transmit DMA Command and Abort Controller

This block holds the command register and the control state machine of one serial transmit DMA channel. A CPU-side register port loads a first-descriptor address and writes a command word carrying a transmit-demand bit and an abort bit. Once demand is set, the controller asks a descriptor-fetch interface for the first descriptor. After the fetch is acknowledged, it runs the transmit process until the process ends with success, a resource error, a channel error such as a lost clear-to-send, or a CPU abort.

The hardware clears the command bits itself, so software learns the outcome by polling. A successful end pulses a descriptor-close strobe. Errors and aborts close nothing. An abort holds the channel in an aborting state for a fixed number of cycles while the abort bit reads back 1. It then returns to idle with both command bits cleared, and it stays disarmed until software writes a fresh descriptor address. Descriptor fetching and data serialisation are outside the block and appear only as handshake pins.

Top module: `txdma_cmd_ctrl`

## Requirements
- R1: After reset the channel is idle. fetch_req, tx_run and desc_close are low, and the command, descriptor-address and status registers all read 0. Register offsets are 0 for command, 1 for descriptor address and 2 for status.
- R2: When the channel is idle and armed, a command write with bit 0 (demand) set raises fetch_req on the next cycle. fetch_addr carries the stored descriptor address, and command bit 0 reads 1.
- R3: fetch_ack moves the channel to transmit, which drops fetch_req and raises tx_run. A tx_done in transmit returns it to idle, clears command bit 0 and gives a single-cycle desc_close pulse.
- R4: A res_err while fetching or transmitting returns the channel to idle with command bit 0 cleared and no desc_close. It also sets status bit 0.
- R5: A chan_err while transmitting returns the channel to idle with command bit 0 cleared and no desc_close. It also sets status bit 1.
- R6: A command write with bit 31 (abort) set drops fetch_req and tx_run on the next cycle. Bit 31 then reads 1 for ABORT_CYCLES cycles. After that, bit 31 and bit 0 both read 0 and the channel is idle.
- R7: desc_close never pulses during an abort, even if tx_done arrives while the channel is aborting.
- R8: If a single command write sets both bit 31 and bit 0, the abort wins and no fetch starts.
- R9: A demand write is ignored until the channel is armed. The channel is disarmed at reset and by every abort, and it is armed by a descriptor-address write accepted while idle.
- R10: Descriptor-address writes made while the channel is not idle are ignored.
- R11: Writing 1 to a status bit clears it. If the matching error arrives in the same cycle, the bit stays set.
- R12: A demand write while the channel is busy does not restart it. A command write with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register offset for write and read |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Registered read data for the offset seen on the previous edge |
| fetch_req | output | 1 | Request for the first descriptor |
| fetch_addr | output | ADDR_W | First-descriptor address |
| fetch_ack | input | 1 | Descriptor fetched |
| tx_run | output | 1 | Transmit process active |
| tx_done | input | 1 | Transmit process finished successfully |
| res_err | input | 1 | Resource error |
| chan_err | input | 1 | Channel error (for example lost clear-to-send) |
| desc_close | output | 1 | Single-cycle descriptor-close strobe |

## Verification
The bench builds the block with ABORT_CYCLES set to 3 instead of the default 2, so software polls see bit 31 high on more than one read and the exact cycle it falls is checked. Both widths stay at 32, so a descriptor address with the top bit set travels to fetch_addr intact. The bench also drives several edge cases at once: an error and a status clear in the same cycle, a done signal during an abort, and abort and demand in one write. These exercise the priority rules directly.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XMIT  = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] RA_CMD  = 2'd0;
  localparam logic [REG_AW-1:0] RA_DESC = 2'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd2;

  localparam int CMD_GO_BIT   = 0;
  localparam int STS_W        = 2;
  localparam int STS_RES_BIT  = 0;
  localparam int STS_CHAN_BIT = 1;
endpackage

// File: rtl/txdma_fsm.sv
module txdma_fsm
  import txdma_pkg::*;
#(
  parameter int ABORT_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_go,
  input  logic      wr_abort,
  input  logic      armed,
  input  logic      fetch_ack,
  input  logic      tx_done,
  input  logic      res_err,
  input  logic      chan_err,
  output tx_state_e state,
  output logic      go_q,
  output logic      abort_q,
  output logic      fetch_req,
  output logic      tx_run,
  output logic      desc_close,
  output logic      res_evt,
  output logic      chan_evt,
  output logic      abort_start
);
  localparam int CNT_W = (ABORT_CYCLES > 1) ? $clog2(ABORT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ABORT_CYCLES - 1);

  tx_state_e        nxt;
  logic [CNT_W-1:0] cnt;
  logic             start, active, done_ok;

  always_comb begin
    active      = (state == ST_FETCH) || (state == ST_XMIT);
    abort_start = wr_abort && (state != ST_ABORT);
    start       = wr_go && !wr_abort && armed && (state == ST_IDLE);
    res_evt     = res_err && active;
    chan_evt    = chan_err && (state == ST_XMIT);
    done_ok     = (state == ST_XMIT) && tx_done && !abort_start && !res_err && !chan_err;
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (abort_start)  nxt = ST_ABORT;
        else if (start)   nxt = ST_FETCH;
      end
      ST_FETCH: begin
        if (abort_start)    nxt = ST_ABORT;
        else if (res_err)   nxt = ST_IDLE;
        else if (fetch_ack) nxt = ST_XMIT;
      end
      ST_XMIT: begin
        if (abort_start)                    nxt = ST_ABORT;
        else if (res_err || chan_err || tx_done) nxt = ST_IDLE;
      end
      ST_ABORT: begin
        if (cnt == '0) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      go_q       <= 1'b0;
      abort_q    <= 1'b0;
      fetch_req  <= 1'b0;
      tx_run     <= 1'b0;
      desc_close <= 1'b0;
    end else begin
      state <= nxt;
      if (abort_start)          cnt <= CNT_LOAD;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
      if (nxt == ST_IDLE)       go_q <= 1'b0;
      else if (start)           go_q <= 1'b1;
      if (abort_start)          abort_q <= 1'b1;
      else if (nxt == ST_IDLE)  abort_q <= 1'b0;
      fetch_req  <= (nxt == ST_FETCH);
      tx_run     <= (nxt == ST_XMIT);
      desc_close <= done_ok;
    end
  end

  assert_close_after_xmit_R3: assert property (@(posedge clk) disable iff (rst)
    desc_close |-> $past(state) == ST_XMIT);
  assert_req_run_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req && tx_run));
  assert_abort_bit_state_R6: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> state == ST_ABORT);
  assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ABORT) |-> (!fetch_req && !tx_run));
  assert_no_close_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ABORT) |-> !desc_close);
  assert_idle_go_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !go_q);
  assert_busy_go_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XMIT && wr_go && !wr_abort && !tx_done && !res_err && !chan_err)
      |=> state == ST_XMIT);
endmodule

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              busy,
  input  logic              abort_start,
  input  logic              res_evt,
  input  logic              chan_evt,
  input  logic              go_q,
  input  logic              abort_q,
  output logic              wr_go,
  output logic              wr_abort,
  output logic              armed,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam int ABORT_BIT = DATA_W - 1;

  logic             wr_cmd, wr_desc, wr_stat;
  logic [STS_W-1:0] sts, sts_set, sts_clr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_cmd   = cpu_wr && (cpu_addr == RA_CMD);
    wr_desc  = cpu_wr && (cpu_addr == RA_DESC) && !busy;
    wr_stat  = cpu_wr && (cpu_addr == RA_STAT);
    wr_go    = wr_cmd && cpu_wdata[CMD_GO_BIT];
    wr_abort = wr_cmd && cpu_wdata[ABORT_BIT];
    sts_set  = '0;
    sts_set[STS_RES_BIT]  = res_evt;
    sts_set[STS_CHAN_BIT] = chan_evt;
    sts_clr  = wr_stat ? cpu_wdata[STS_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_addr <= '0;
      armed     <= 1'b0;
    end else begin
      if (wr_desc) desc_addr <= cpu_wdata[ADDR_W-1:0];
      if (abort_start)  armed <= 1'b0;
      else if (wr_desc) armed <= 1'b1;
    end
  end

  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (rst)             sts[i] <= 1'b0;
      else if (sts_set[i]) sts[i] <= 1'b1;
      else if (sts_clr[i]) sts[i] <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cpu_addr)
      RA_CMD: begin
        rd_mux[ABORT_BIT]  = abort_q;
        rd_mux[CMD_GO_BIT] = go_q;
      end
      RA_DESC: rd_mux[ADDR_W-1:0] = desc_addr;
      RA_STAT: rd_mux[STS_W-1:0]  = sts;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_mux;
  end

  assert_res_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    res_evt |=> sts[STS_RES_BIT]);
  assert_chan_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    chan_evt |=> sts[STS_CHAN_BIT]);
  assert_desc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_wr && cpu_addr == RA_DESC) |=> $stable(desc_addr));
  assert_disarm_R9: assert property (@(posedge clk) disable iff (rst)
    abort_start |=> !armed);
endmodule

// File: rtl/txdma_cmd_ctrl.sv
module txdma_cmd_ctrl
  import txdma_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int ABORT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  output logic              tx_run,
  input  logic              tx_done,
  input  logic              res_err,
  input  logic              chan_err,
  output logic              desc_close
);
  tx_state_e state;
  logic wr_go, wr_abort, armed, go_q, abort_q;
  logic res_evt, chan_evt, abort_start, busy;

  assign busy = (state != ST_IDLE);

  txdma_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .busy(busy), .abort_start(abort_start),
    .res_evt(res_evt), .chan_evt(chan_evt), .go_q(go_q), .abort_q(abort_q),
    .wr_go(wr_go), .wr_abort(wr_abort), .armed(armed),
    .desc_addr(fetch_addr), .cpu_rdata(cpu_rdata)
  );

  txdma_fsm #(.ABORT_CYCLES(ABORT_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_abort(wr_abort), .armed(armed),
    .fetch_ack(fetch_ack), .tx_done(tx_done), .res_err(res_err),
    .chan_err(chan_err), .state(state), .go_q(go_q), .abort_q(abort_q),
    .fetch_req(fetch_req), .tx_run(tx_run), .desc_close(desc_close),
    .res_evt(res_evt), .chan_evt(chan_evt), .abort_start(abort_start)
  );
endmodule

// File: tb/tb_txdma_cmd_ctrl.sv
module tb_txdma_cmd_ctrl;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int AB = 3;
  localparam logic [DW-1:0] ABORT_W = 32'h8000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_wr = 0, fetch_ack = 0, tx_done = 0, res_err = 0, chan_err = 0;
  logic [1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, cpu_rdata;
  logic fetch_req, tx_run, desc_close;
  logic [AW-1:0] fetch_addr;
  int n_run = 0, n_fail = 0, cyc = 0, closes = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (desc_close) closes++;

  txdma_cmd_ctrl #(.DATA_W(DW), .ADDR_W(AW), .ABORT_CYCLES(AB)) dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .tx_run(tx_run),
    .tx_done(tx_done), .res_err(res_err), .chan_err(chan_err),
    .desc_close(desc_close)
  );

  // {address, ending kind (0 done, 1 res in tx, 2 chan in tx, 3 res in fetch), close, status}
  localparam logic [36:0] VEC [6] = '{
    {32'h1000_0040, 2'd0, 1'b1, 2'b00},
    {32'h2000_0100, 2'd1, 1'b0, 2'b01},
    {32'h0000_0FF0, 2'd2, 1'b0, 2'b10},
    {32'hFFFF_FFFC, 2'd3, 1'b0, 2'b01},
    {32'h0000_0004, 2'd0, 1'b1, 2'b00},
    {32'h8000_0000, 2'd2, 1'b0, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1; cpu_wr = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); cpu_wr = 0; cpu_addr = a;
    @(posedge clk); #1; d = cpu_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: fetch_ack = 1;
      1: tx_done = 1;
      2: res_err = 1;
      default: chan_err = 1;
    endcase
    @(posedge clk); #1;
    fetch_ack = 0; tx_done = 0; res_err = 0; chan_err = 0;
  endtask

  task automatic start_xmit(input logic [AW-1:0] a);
    reg_wr(2'd1, a);
    reg_wr(2'd0, 32'h1);
    pulse(0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int c0;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 fetch_req", {31'b0, fetch_req}, 0);
    chk("R1 tx_run", {31'b0, tx_run}, 0);
    chk("R1 desc_close", {31'b0, desc_close}, 0);
    reg_rd(2'd0, rd); chk("R1 cmd", rd, 0);
    reg_rd(2'd1, rd); chk("R1 desc", rd, 0);
    reg_rd(2'd2, rd); chk("R1 status", rd, 0);
    // R9 not armed out of reset
    reg_wr(2'd0, 32'h1);
    chk("R9 unarmed demand", {31'b0, fetch_req}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] a; logic [1:0] kind; logic ecl; logic [1:0] est;
      {a, kind, ecl, est} = VEC[i];
      reg_wr(2'd1, a);
      reg_wr(2'd0, 32'h1);
      chk("R2 fetch_req", {31'b0, fetch_req}, 1);
      chk("R2 fetch_addr", fetch_addr, a);
      reg_rd(2'd0, rd); chk("R2 cmd demand", rd, 32'h1);
      c0 = closes;
      if (kind == 2'd3) begin
        pulse(2);
        chk("R4 fetch err idle", {30'b0, fetch_req, tx_run}, 0);
      end else begin
        pulse(0);
        chk("R3 tx_run", {30'b0, fetch_req, tx_run}, 1);
        pulse(kind == 0 ? 1 : (kind == 1 ? 2 : 3));
        chk("R3 run ends", {31'b0, tx_run}, 0);
        if (kind == 0) chk("R3 close pulse", {31'b0, desc_close}, 1);
      end
      tick();
      chk("R3 close single", {31'b0, desc_close}, 0);
      chk("R4 R5 close count", closes - c0, {31'b0, ecl});
      reg_rd(2'd0, rd); chk("R4 R5 cmd cleared", rd, 0);
      reg_rd(2'd2, rd); chk("R4 R5 status", rd, {30'b0, est});
      reg_wr(2'd2, 32'h3);
      reg_rd(2'd2, rd); chk("R11 w1c", rd, 0);
    end

    // R10, R12: writes while busy
    start_xmit(32'h0000_0A00);
    reg_wr(2'd1, 32'h0000_0B00);
    reg_rd(2'd1, rd); chk("R10 desc held", rd, 32'h0000_0A00);
    reg_wr(2'd0, 32'h1);
    chk("R12 still running", {31'b0, tx_run}, 1);
    pulse(1);
    tick();
    chk("R12 no restart", {30'b0, fetch_req, tx_run}, 0);
    reg_wr(2'd0, 32'h0);
    chk("R12 zero write", {31'b0, fetch_req}, 0);

    // R6, R7: abort during transmit
    start_xmit(32'h0000_0C00);
    c0 = closes;
    reg_wr(2'd0, ABORT_W);
    chk("R6 outputs drop", {30'b0, fetch_req, tx_run}, 0);
    pulse(1);
    for (int k = 2; k <= AB; k++) begin
      reg_rd(2'd0, rd); chk("R6 abort polled", rd, 32'h8000_0001);
    end
    reg_rd(2'd0, rd); chk("R6 abort finished", rd, 0);
    chk("R7 no close", closes - c0, 0);

    // R9: disarmed after abort
    reg_wr(2'd0, 32'h1);
    chk("R9 demand ignored", {31'b0, fetch_req}, 0);
    reg_rd(2'd0, rd); chk("R9 cmd", rd, 0);
    reg_wr(2'd1, 32'h0000_0D00);
    reg_wr(2'd0, 32'h1);
    chk("R9 rearmed", {31'b0, fetch_req}, 1);
    reg_wr(2'd0, ABORT_W);
    chk("R6 fetch abort", {31'b0, fetch_req}, 0);
    repeat (AB + 1) tick();

    // R8: abort and demand in one write
    reg_wr(2'd1, 32'h0000_0E00);
    reg_wr(2'd0, 32'h8000_0001);
    chk("R8 no fetch", {31'b0, fetch_req}, 0);
    reg_rd(2'd0, rd); chk("R8 abort only", rd, 32'h8000_0000);
    repeat (AB) tick();
    reg_rd(2'd0, rd); chk("R8 cmd clear", rd, 0);
    chk("R8 still idle", {31'b0, fetch_req}, 0);

    // R11: set wins over clear
    start_xmit(32'h0000_0F00);
    @(negedge clk); cpu_wr = 1; cpu_addr = 2'd2; cpu_wdata = 32'h1; res_err = 1;
    @(posedge clk); #1; cpu_wr = 0; res_err = 0;
    reg_rd(2'd2, rd); chk("R11 set wins", rd, 32'h1);
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, rd); chk("R11 cleared", rd, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule